// File: doc/BRIEF.md
# Burst and Deep-Burst Mode Controller

This block decides, once per clock, whether a flyback PWM stage may switch and whether it should sit in a low-power deep-burst state. It receives four comparator results that are already digitised: feedback under the zero-duty level, feedback over the recovery level, supply under the impedance-switch level, and feedback over the exit level. It also receives a strobe for every gate pulse and a millisecond tick. It drives a switching enable, a deep-burst flag, a select that moves the external comparators to the higher threshold pair, and an enable for the feedback impedance modulator.

In ordinary burst operation the switching enable follows a hysteresis pair of feedback flags. When three bursts in a row each stay idle for at least `IDLE_MS` ticks, a qualification window of `QUAL_MS` ticks opens. A run of more than `PULSE_RUN` consecutive gate pulses cancels the window. If the window expires, deep burst starts. In deep burst the comparators use the higher threshold pair. Switching stays off until the supply-low flag releases the impedance modulator. The state ends after a long pulse run, or at once when the exit flag rises while switching is suspended.

All control pins are plain level or strobe signals. The block has no streaming data path, so no valid/ready handshake applies. Reset is synchronous and active high.

Top module: `burst_ctrl`

## Requirements
- R1: In the cycle after `rst` is sampled high, `sw_enable` is 1 and `deep_active`, `thr_high_sel` and `imod_enable` are 0. All internal counts restart from zero.
- R2: While `sw_enable` is 1, `fb_below_zd` clears it at the next edge. Outside deep burst, while `sw_enable` is 0, `fb_above_rec` sets it at the next edge. With neither flag active, it holds its value.
- R3: An idle interval counts as long when `sw_enable` stays 0 for at least `IDLE_MS` ticks of `ms_tick`. Qualification begins only when `CAND_RUNS` long intervals occur in a row. A shorter idle interval restarts that count from zero.
- R4: Once qualification has begun, `deep_active` rises in the cycle after the `QUAL_MS`-th tick and not before it.
- R5: During qualification, a run of `PULSE_RUN`+1 consecutive gate pulses abandons entry into deep burst. A run of exactly `PULSE_RUN` pulses does not.
- R6: `thr_high_sel` is 1 exactly while `deep_active` is 1, which selects the higher zero-duty/recovery pair.
- R7: In deep burst, once switching has stopped, `fb_above_rec` alone does not restart it. `vdd_below_zsw` sets `imod_enable` at the next edge. After that, `fb_above_rec` restarts switching. `imod_enable` clears when switching stops again and is never 1 outside deep burst.
- R8: In deep burst, `PULSE_RUN`+1 consecutive gate pulses end deep burst. `deep_active`, `thr_high_sel` and `imod_enable` then all return to 0.
- R9: In deep burst with `sw_enable` at 0, `fb_above_exit` ends deep burst at the next edge. The same flag while `sw_enable` is 1 has no effect.
- R10: If `GAP_CYC` clock cycles pass without a gate pulse, the consecutive-pulse count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_below_zd | input | 1 | Feedback is under the selected zero-duty level |
| fb_above_rec | input | 1 | Feedback is over the selected recovery level |
| vdd_below_zsw | input | 1 | Supply is under the impedance-switch level |
| fb_above_exit | input | 1 | Feedback is over the deep-burst exit level |
| gate_strobe | input | 1 | One-cycle strobe for each gate pulse |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| sw_enable | output | 1 | Gate switching allowed |
| deep_active | output | 1 | Deep burst in effect |
| thr_high_sel | output | 1 | Comparators use the higher threshold pair |
| imod_enable | output | 1 | Impedance modulator lets feedback rise |

## Verification
The bench targets the following corner cases, each with the failure a faulty design would show:
- **Streak reset:** a short idle burst between long ones must restart the streak. A design that only counts long bursts would enter deep burst one burst too early.
- **Qualification boundaries:** the window is probed one tick before expiry and on the expiring tick. An off-by-one in the tick counter would assert the deep flag early or late.
- **Pulse-run length:** runs of exactly `PULSE_RUN` pulses and of one more are both applied, during qualification and inside deep burst. A wrong compare would either cancel entry too readily or never leave deep burst.
- **Gap reset:** a long pause in the middle of a run must restart the count. A design without it would exit deep burst early.
- **Deep-burst gating:** the recovery flag is applied before the supply flag, and the exit flag is applied while switching. A design that forgot the modulator gating, or did not tie the exit to suspension, would resume or leave deep burst at the wrong time.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_QUALIFY = 2'd1,
    MODE_DEEP    = 2'd2
  } burst_mode_e;
endpackage

// File: rtl/burst_idle_streak.sv
// Measures each non-switching interval in ms ticks and counts how many
// long intervals occurred back to back.
module burst_idle_streak #(
  parameter int IDLE_MS   = 8,
  parameter int CAND_RUNS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic enable,
  input  logic sw_en,
  input  logic ms_tick,
  output logic candidate
);
  localparam int IW = $clog2(IDLE_MS + 1);
  localparam int SW = $clog2(CAND_RUNS + 1);
  localparam logic [IW-1:0] IDLE_LIM = IW'(IDLE_MS);
  localparam logic [SW-1:0] RUN_LIM  = SW'(CAND_RUNS);

  logic [IW-1:0] idle_q;
  logic [SW-1:0] streak_q;
  logic          prev_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idle_q   <= '0;
      streak_q <= '0;
      prev_q   <= 1'b1;
    end else if (enable) begin
      prev_q <= sw_en;
      if (sw_en && !prev_q) begin
        // Switching just resumed: judge the interval that ended.
        if (idle_q >= IDLE_LIM) begin
          if (streak_q != RUN_LIM) streak_q <= streak_q + 1'b1;
        end else begin
          streak_q <= '0;
        end
        idle_q <= '0;
      end else if (!sw_en && ms_tick && (idle_q != IDLE_LIM)) begin
        idle_q <= idle_q + 1'b1;
      end
    end else begin
      prev_q <= sw_en;
    end
  end

  assign candidate = (streak_q == RUN_LIM);
endmodule

// File: rtl/burst_pulse_run.sv
// Counts consecutive gate pulses; a silent stretch of GAP_CYC cycles
// breaks the run.
module burst_pulse_run #(
  parameter int PULSE_RUN = 112,
  parameter int GAP_CYC   = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic gate_pulse,
  output logic run_long
);
  localparam int CW = $clog2(PULSE_RUN + 2);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(PULSE_RUN + 1);
  localparam logic [GW-1:0] GAP_TOP = GW'(GAP_CYC);
  localparam logic [GW-1:0] GAP_HIT = GW'(GAP_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      gap_q <= '0;
    end else if (gate_pulse) begin
      gap_q <= '0;
      if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end else begin
      if (gap_q != GAP_TOP) gap_q <= gap_q + 1'b1;
      if (gap_q >= GAP_HIT) cnt_q <= '0;
    end
  end

  assign run_long = (cnt_q == CNT_TOP);
endmodule

// File: rtl/burst_qual_timer.sv
// Millisecond window that runs only while armed.
module burst_qual_timer #(
  parameter int QUAL_MS = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic ms_tick,
  output logic done
);
  localparam int QW = $clog2(QUAL_MS + 1);
  localparam logic [QW-1:0] QUAL_LIM = QW'(QUAL_MS);

  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      cnt_q <= '0;
    end else if (ms_tick && (cnt_q != QUAL_LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == QUAL_LIM);
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int IDLE_MS   = 8,
  parameter int CAND_RUNS = 3,
  parameter int QUAL_MS   = 600,
  parameter int PULSE_RUN = 112,
  parameter int GAP_CYC   = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic fb_below_zd,
  input  logic fb_above_rec,
  input  logic vdd_below_zsw,
  input  logic fb_above_exit,
  input  logic gate_strobe,
  input  logic ms_tick,
  output logic sw_enable,
  output logic deep_active,
  output logic thr_high_sel,
  output logic imod_enable
);
  burst_mode_e mode_q, mode_nx;
  logic sw_q, sw_nx;
  logic imod_q, imod_nx;
  logic candidate, run_long, qual_done, mode_change;

  assign mode_change = (mode_nx != mode_q);

  burst_idle_streak #(.IDLE_MS(IDLE_MS), .CAND_RUNS(CAND_RUNS)) u_streak (
    .clk(clk), .rst(rst), .clr(mode_change),
    .enable(mode_q == MODE_NORMAL),
    .sw_en(sw_q), .ms_tick(ms_tick), .candidate(candidate)
  );

  burst_pulse_run #(.PULSE_RUN(PULSE_RUN), .GAP_CYC(GAP_CYC)) u_run (
    .clk(clk), .rst(rst), .clr(mode_change),
    .gate_pulse(gate_strobe), .run_long(run_long)
  );

  burst_qual_timer #(.QUAL_MS(QUAL_MS)) u_qual (
    .clk(clk), .rst(rst), .arm(mode_q == MODE_QUALIFY),
    .ms_tick(ms_tick), .done(qual_done)
  );

  // Mode sequencing
  always_comb begin
    mode_nx = mode_q;
    unique case (mode_q)
      MODE_NORMAL:  if (candidate) mode_nx = MODE_QUALIFY;
      MODE_QUALIFY: begin
        if (run_long)       mode_nx = MODE_NORMAL;
        else if (qual_done) mode_nx = MODE_DEEP;
      end
      MODE_DEEP: begin
        if (!sw_q && fb_above_exit) mode_nx = MODE_NORMAL;
        else if (run_long)          mode_nx = MODE_NORMAL;
      end
      default: mode_nx = MODE_NORMAL;
    endcase
  end

  // Switching hysteresis; in deep burst a restart also needs the modulator
  always_comb begin
    sw_nx = sw_q;
    if (sw_q && fb_below_zd) begin
      sw_nx = 1'b0;
    end else if (!sw_q && fb_above_rec) begin
      if (mode_q != MODE_DEEP || imod_q) sw_nx = 1'b1;
    end
  end

  always_comb begin
    imod_nx = imod_q;
    if (mode_nx != MODE_DEEP)                           imod_nx = 1'b0;
    else if (sw_q && fb_below_zd)                       imod_nx = 1'b0;
    else if (mode_q == MODE_DEEP && !sw_q && vdd_below_zsw) imod_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_NORMAL;
      sw_q   <= 1'b1;
      imod_q <= 1'b0;
    end else begin
      mode_q <= mode_nx;
      sw_q   <= sw_nx;
      imod_q <= imod_nx;
    end
  end

  assign sw_enable    = sw_q;
  assign deep_active  = (mode_q == MODE_DEEP);
  assign thr_high_sel = (mode_q == MODE_DEEP);
  assign imod_enable  = imod_q;
endmodule

// File: rtl/burst_ctrl_chk.sv
module burst_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic fb_below_zd,
  input logic fb_above_rec,
  input logic fb_above_exit,
  input logic sw_enable,
  input logic deep_active,
  input logic imod_enable
);
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (sw_enable && !deep_active && !imod_enable));

  p_stop_on_low_r2: assert property (@(posedge clk) disable iff (rst)
    (sw_enable && fb_below_zd) |=> !sw_enable);

  p_start_on_rec_r2: assert property (@(posedge clk) disable iff (rst)
    (!deep_active && !sw_enable && fb_above_rec) |=> sw_enable);

  p_imod_deep_only_r7: assert property (@(posedge clk) disable iff (rst)
    imod_enable |-> deep_active);

  p_no_restart_unreleased_r7: assert property (@(posedge clk) disable iff (rst)
    (deep_active && !sw_enable && !imod_enable) |=> !sw_enable);

  p_exit_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (deep_active && !sw_enable && fb_above_exit) |=> !deep_active);
endmodule

bind burst_ctrl burst_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .fb_below_zd(fb_below_zd), .fb_above_rec(fb_above_rec),
  .fb_above_exit(fb_above_exit), .sw_enable(sw_enable),
  .deep_active(deep_active), .imod_enable(imod_enable)
);

// File: tb/burst_ctrl_test.sv
module burst_ctrl_test;
  localparam int IDLE_MS = 3, CAND_RUNS = 3, QUAL_MS = 10, PULSE_RUN = 5, GAP_CYC = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_below_zd = 0, fb_above_rec = 0, vdd_below_zsw = 0, fb_above_exit = 0;
  logic gate_strobe = 0, ms_tick = 0;
  logic sw_enable, deep_active, thr_high_sel, imod_enable;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  burst_ctrl #(.IDLE_MS(IDLE_MS), .CAND_RUNS(CAND_RUNS), .QUAL_MS(QUAL_MS),
               .PULSE_RUN(PULSE_RUN), .GAP_CYC(GAP_CYC)) uut (
    .clk(clk), .rst(rst), .fb_below_zd(fb_below_zd), .fb_above_rec(fb_above_rec),
    .vdd_below_zsw(vdd_below_zsw), .fb_above_exit(fb_above_exit),
    .gate_strobe(gate_strobe), .ms_tick(ms_tick), .sw_enable(sw_enable),
    .deep_active(deep_active), .thr_high_sel(thr_high_sel), .imod_enable(imod_enable)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      ms_tick = 1; cyc(1); ms_tick = 0; cyc(1);
    end
  endtask

  task automatic pulses(int n);
    repeat (n) begin
      gate_strobe = 1; cyc(1); gate_strobe = 0; cyc(2);
    end
  endtask

  // stop switching, stay idle for n ticks, resume
  task automatic burst(int n);
    fb_below_zd = 1; cyc(1); fb_below_zd = 0;
    ticks(n);
    fb_above_rec = 1; cyc(1); fb_above_rec = 0;
    cyc(4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cyc(2); rst = 0;
  endtask

  task automatic t_reset();
    chk("R1", "sw_enable", sw_enable, 1'b1);
    chk("R1", "deep_active", deep_active, 1'b0);
    chk("R1", "thr_high_sel", thr_high_sel, 1'b0);
    chk("R1", "imod_enable", imod_enable, 1'b0);
  endtask

  task automatic t_hysteresis();
    fb_below_zd = 1; cyc(1); fb_below_zd = 0;
    chk("R2", "off after low", sw_enable, 1'b0);
    cyc(3);
    chk("R2", "holds off", sw_enable, 1'b0);
    fb_above_rec = 1; cyc(1); fb_above_rec = 0;
    chk("R2", "on after recover", sw_enable, 1'b1);
    cyc(3);
    chk("R2", "holds on", sw_enable, 1'b1);
  endtask

  task automatic t_streak_and_qual();
    burst(IDLE_MS); burst(1); burst(IDLE_MS); burst(IDLE_MS);
    ticks(QUAL_MS + 2);
    chk("R3", "short idle restarts streak", deep_active, 1'b0);
    burst(IDLE_MS);
    ticks(QUAL_MS - 1);
    chk("R4", "not deep one tick early", deep_active, 1'b0);
    ticks(1);
    chk("R4", "deep after window", deep_active, 1'b1);
    chk("R6", "high thresholds in deep", thr_high_sel, 1'b1);
  endtask

  task automatic t_exit_flag();
    fb_above_exit = 1; cyc(2); fb_above_exit = 0;
    chk("R9", "exit flag ignored while switching", deep_active, 1'b1);
    fb_below_zd = 1; cyc(1); fb_below_zd = 0;
    fb_above_exit = 1; cyc(1); fb_above_exit = 0;
    chk("R9", "exit flag while idle", deep_active, 1'b0);
    chk("R6", "normal thresholds after exit", thr_high_sel, 1'b0);
    fb_above_rec = 1; cyc(1); fb_above_rec = 0; cyc(2);
  endtask

  task automatic t_abandon();
    burst(IDLE_MS); burst(IDLE_MS); burst(IDLE_MS);
    pulses(PULSE_RUN + 1);
    ticks(QUAL_MS + 2);
    chk("R5", "long pulse run cancels entry", deep_active, 1'b0);
    burst(IDLE_MS); burst(IDLE_MS); burst(IDLE_MS);
    pulses(PULSE_RUN);
    ticks(QUAL_MS);
    chk("R5", "exactly PULSE_RUN pulses keeps entry", deep_active, 1'b1);
  endtask

  task automatic t_deep_gating();
    fb_below_zd = 1; cyc(1); fb_below_zd = 0;
    chk("R7", "switching stops in deep", sw_enable, 1'b0);
    fb_above_rec = 1; cyc(2); fb_above_rec = 0;
    chk("R7", "recover alone ignored", sw_enable, 1'b0);
    chk("R7", "modulator still off", imod_enable, 1'b0);
    vdd_below_zsw = 1; cyc(1); vdd_below_zsw = 0;
    chk("R7", "supply low releases modulator", imod_enable, 1'b1);
    fb_above_rec = 1; cyc(1); fb_above_rec = 0;
    chk("R7", "restart after release", sw_enable, 1'b1);
    fb_below_zd = 1; cyc(1); fb_below_zd = 0;
    chk("R7", "modulator clears on stop", imod_enable, 1'b0);
    vdd_below_zsw = 1; cyc(1); vdd_below_zsw = 0;
    fb_above_rec = 1; cyc(1); fb_above_rec = 0;
  endtask

  task automatic t_pulse_exit();
    pulses(PULSE_RUN);
    cyc(2 * GAP_CYC);
    pulses(PULSE_RUN);
    chk("R10", "gap restarts run", deep_active, 1'b1);
    pulses(1);
    chk("R8", "deep ends after long run", deep_active, 1'b0);
    chk("R8", "thresholds back", thr_high_sel, 1'b0);
    chk("R8", "modulator back", imod_enable, 1'b0);
  endtask

  task automatic t_reset_in_deep();
    burst(IDLE_MS); burst(IDLE_MS); burst(IDLE_MS);
    ticks(QUAL_MS);
    chk("R4", "deep again", deep_active, 1'b1);
    fb_below_zd = 1; cyc(1); fb_below_zd = 0;
    do_reset();
    t_reset();
  endtask

  initial begin
    fork
      begin
        cyc(3); rst = 0;
        t_reset();
        t_hysteresis();
        t_streak_and_qual();
        t_exit_flag();
        t_abandon();
        t_deep_gating();
        t_pulse_exit();
        t_reset_in_deep();
      end
      begin
        cyc(150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule